// File: doc/BRIEF.md
# UART DMA Request Steering

This block connects the status flags of one or more UARTs to a multi-channel DMA controller. For each UART it takes a receive flag and a transmit-ready flag and drives a request strobe on a DMA channel chosen by software. Each request stands for the transfer of one byte. A per-channel acknowledge withdraws the strobe so that a flag that is slow to clear cannot start a second transfer.

At the same time the block builds a single interrupt line from the same status. Each UART presents four conditions: transmit ready, receive, CTS change and break change. Each condition has its own enable bit in a mask register. Software clears the mask bits of conditions that DMA serves. CTS-change and break-change events can stay enabled, so they still reach the CPU while data streams through DMA.

Top module: `uart_dma_steer`

## Requirements
- R1: While `rst_ni` is low, every bit of `dma_req_o` and `irq_o` is 0.
- R2: The receive flag of UART u is `rx_full_i[u]` when `rx_use_full_i[u]` is 1, and `rx_rdy_i[u]` when it is 0.
- R3: The transmit flag of UART u is `tx_rdy_i[u]`, and it requests its mapped channel while set.
- R4: `req_map_i` holds one 4-bit field per source. The receive field of UART u is at bits [8u+7:8u+4] and the transmit field at bits [8u+11:8u+8]. Within a field, bit 3 set enables the source and bits 2:0 give the channel number. A field with bit 3 clear, or a channel number of `NUM_CH` or above, drives no channel.
- R5: Sources mapped to the same channel are ORed onto that channel's request.
- R6: `dma_req_o` is registered. A flag present in one cycle shows on its channel in the next cycle. When all flags are clear, all requests are 0 in the next cycle.
- R7: When `dma_ack_i[c]` is high while `dma_req_o[c]` is high, `dma_req_o[c]` is 0 for the next two cycles. It then follows the flags again.
- R8: `dma_ack_i[c]` sampled while `dma_req_o[c]` is 0 has no effect.
- R9: The status bits of UART u are: bit 0 transmit flag, bit 1 receive flag, bit 2 `cts_chg_i[u]`, bit 3 `brk_chg_i[u]`. The enable for status bit b is `irq_mask_i[4u+b]`. `irq_o` is the OR of all enabled status bits, registered once.
- R10: An enabled CTS-change or break-change condition raises `irq_o` in the next cycle, whatever the mapping and DMA state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_rdy_i | input | NUM_UART | Receive-ready flag per UART |
| rx_full_i | input | NUM_UART | FIFO-full flag per UART |
| rx_use_full_i | input | NUM_UART | 1 selects FIFO-full as the receive flag |
| tx_rdy_i | input | NUM_UART | Transmitter-ready flag per UART |
| cts_chg_i | input | NUM_UART | CTS change-of-state event per UART |
| brk_chg_i | input | NUM_UART | Break change event per UART |
| irq_mask_i | input | 4*NUM_UART | Interrupt enables, 4 per UART |
| req_map_i | input | 8*NUM_UART+4 | Source-to-channel mapping fields |
| dma_ack_i | input | NUM_CH | DMA acknowledge per channel |
| dma_req_o | output | NUM_CH | DMA request per channel |
| irq_o | output | 1 | UART interrupt |

## Verification
The hardest situation to reach from the ports is an acknowledge that arrives while the flag stays high. Only then does the two-cycle hold-off show. Otherwise the request simply falls and rises again with the flag. The random phase keeps flags high with good probability, draws acknowledges per channel independently of the request state, and remaps sources so that several of them often share a channel. Directed cases also pin down an acknowledge held against a steady flag, an acknowledge that lands on an idle channel, and a CTS event on a UART whose data path is fully routed to DMA.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  localparam int FLD_W = 4;
  localparam int ST_W  = 4;
  localparam int ST_TX  = 0;
  localparam int ST_RX  = 1;
  localparam int ST_CTS = 2;
  localparam int ST_BRK = 3;

  typedef struct packed {
    logic       en;
    logic [2:0] ch;
  } map_fld_t;
endpackage

// File: rtl/uart_dma_src.sv
module uart_dma_src
  import uart_dma_pkg::*;
(
  input  logic            rx_rdy_i,
  input  logic            rx_full_i,
  input  logic            rx_use_full_i,
  input  logic            tx_rdy_i,
  input  logic            cts_chg_i,
  input  logic            brk_chg_i,
  output logic            rx_flag_o,
  output logic            tx_flag_o,
  output logic [ST_W-1:0] status_o
);
  assign rx_flag_o = rx_use_full_i ? rx_full_i : rx_rdy_i;
  assign tx_flag_o = tx_rdy_i;

  always_comb begin
    status_o         = '0;
    status_o[ST_TX]  = tx_flag_o;
    status_o[ST_RX]  = rx_flag_o;
    status_o[ST_CTS] = cts_chg_i;
    status_o[ST_BRK] = brk_chg_i;
  end
endmodule

// File: rtl/uart_dma_route.sv
module uart_dma_route
  import uart_dma_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_CH  = 8
) (
  input  logic     [NUM_SRC-1:0] flag_i,
  input  map_fld_t [NUM_SRC-1:0] fld_i,
  output logic     [NUM_CH-1:0]  raw_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      raw_o[c] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (fld_i[s].en && (int'(fld_i[s].ch) == c) && flag_i[s]) raw_o[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_dma_chan.sv
module uart_dma_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic ack_i,
  output logic req_o
);
  logic hold_q;
  logic taken;

  assign taken = ack_i & req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      // one extra idle cycle after a taken request avoids a second transfer
      req_o  <= raw_i & ~taken & ~hold_q;
      hold_q <= taken;
    end
  end
endmodule

// File: rtl/uart_dma_steer.sv
module uart_dma_steer
  import uart_dma_pkg::*;
#(
  parameter int NUM_UART = 2,
  parameter int NUM_CH   = 8,
  localparam int NUM_SRC = 2 * NUM_UART,
  localparam int MAP_W   = 8 * NUM_UART + FLD_W,
  localparam int MSK_W   = ST_W * NUM_UART
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_UART-1:0] rx_rdy_i,
  input  logic [NUM_UART-1:0] rx_full_i,
  input  logic [NUM_UART-1:0] rx_use_full_i,
  input  logic [NUM_UART-1:0] tx_rdy_i,
  input  logic [NUM_UART-1:0] cts_chg_i,
  input  logic [NUM_UART-1:0] brk_chg_i,
  input  logic [MSK_W-1:0]    irq_mask_i,
  input  logic [MAP_W-1:0]    req_map_i,
  input  logic [NUM_CH-1:0]   dma_ack_i,
  output logic [NUM_CH-1:0]   dma_req_o,
  output logic                irq_o
);
  logic     [NUM_SRC-1:0] src_flag;
  map_fld_t [NUM_SRC-1:0] src_fld;
  logic     [MSK_W-1:0]   status;
  logic     [NUM_CH-1:0]  raw;

  for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
    logic rx_flag, tx_flag;

    uart_dma_src u_src (
      .rx_rdy_i      (rx_rdy_i[u]),
      .rx_full_i     (rx_full_i[u]),
      .rx_use_full_i (rx_use_full_i[u]),
      .tx_rdy_i      (tx_rdy_i[u]),
      .cts_chg_i     (cts_chg_i[u]),
      .brk_chg_i     (brk_chg_i[u]),
      .rx_flag_o     (rx_flag),
      .tx_flag_o     (tx_flag),
      .status_o      (status[ST_W*u +: ST_W])
    );

    // even source = receive, odd source = transmit
    assign src_flag[2*u]   = rx_flag;
    assign src_flag[2*u+1] = tx_flag;
    assign src_fld[2*u]    = map_fld_t'(req_map_i[8*u+4 +: FLD_W]);
    assign src_fld[2*u+1]  = map_fld_t'(req_map_i[8*u+8 +: FLD_W]);
  end

  uart_dma_route #(
    .NUM_SRC (NUM_SRC),
    .NUM_CH  (NUM_CH)
  ) u_route (
    .flag_i (src_flag),
    .fld_i  (src_fld),
    .raw_o  (raw)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    uart_dma_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[c]),
      .ack_i  (dma_ack_i[c]),
      .req_o  (dma_req_o[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(status & irq_mask_i);
  end

  // bits 3:0 of req_map_i carry no field
  logic unused_map;
  assign unused_map = ^req_map_i[FLD_W-1:0];
endmodule

// File: rtl/uart_dma_steer_chk.sv
module uart_dma_steer_chk #(
  parameter int NUM_UART = 2,
  parameter int NUM_CH   = 8,
  localparam int MAP_W   = 8 * NUM_UART + 4,
  localparam int MSK_W   = 4 * NUM_UART
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_UART-1:0] rx_rdy_i,
  input logic [NUM_UART-1:0] rx_full_i,
  input logic [NUM_UART-1:0] rx_use_full_i,
  input logic [NUM_UART-1:0] tx_rdy_i,
  input logic [NUM_UART-1:0] cts_chg_i,
  input logic [NUM_UART-1:0] brk_chg_i,
  input logic [MSK_W-1:0]    irq_mask_i,
  input logic [MAP_W-1:0]    req_map_i,
  input logic [NUM_CH-1:0]   dma_ack_i,
  input logic [NUM_CH-1:0]   dma_req_o,
  input logic                irq_o
);
  logic evt;
  logic any_flag;

  always_comb begin
    evt = 1'b0;
    for (int u = 0; u < NUM_UART; u++)
      evt |= (cts_chg_i[u] & irq_mask_i[4*u+2]) | (brk_chg_i[u] & irq_mask_i[4*u+3]);
  end
  assign any_flag = |{rx_rdy_i, rx_full_i, tx_rdy_i};

  always_comb if (!rst_ni) AST_RESET_QUIET: assert (dma_req_o == '0 && !irq_o); // R1

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_flag |=> dma_req_o == '0); // R6

  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & dma_ack_i) != '0 |=> (dma_req_o & $past(dma_req_o & dma_ack_i)) == '0); // R7

  AST_ACK_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & $past(dma_req_o & dma_ack_i, 2)) == '0); // R7

  AST_MASK_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_i == '0 |=> !irq_o); // R9

  AST_EVT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> irq_o); // R10
endmodule

bind uart_dma_steer uart_dma_steer_chk #(.NUM_UART(NUM_UART), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/uart_dma_steer_test.sv
module uart_dma_steer_test;
  localparam int NU = 2;
  localparam int NC = 8;
  localparam int MW = 8 * NU + 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NU-1:0] rx_rdy_i = '0, rx_full_i = '0, rx_use_full_i = '0, tx_rdy_i = '0;
  logic [NU-1:0] cts_chg_i = '0, brk_chg_i = '0;
  logic [4*NU-1:0] irq_mask_i = '0;
  logic [MW-1:0] req_map_i = '0;
  logic [NC-1:0] dma_ack_i = '0;
  logic [NC-1:0] dma_req_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  uart_dma_steer #(.NUM_UART(NU), .NUM_CH(NC)) uut (.*);

  // reference model built from the requirements
  logic [NC-1:0] m_req, m_hold;
  logic m_irq;

  function automatic logic [NC-1:0] exp_raw();
    logic [NC-1:0] r = '0;
    for (int u = 0; u < NU; u++) begin
      logic rxf = rx_use_full_i[u] ? rx_full_i[u] : rx_rdy_i[u];
      logic [3:0] fr = req_map_i[8*u+4 +: 4];
      logic [3:0] ft = req_map_i[8*u+8 +: 4];
      if (fr[3] && int'(fr[2:0]) < NC && rxf) r[fr[2:0]] = 1'b1;
      if (ft[3] && int'(ft[2:0]) < NC && tx_rdy_i[u]) r[ft[2:0]] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic exp_irq();
    logic i = 1'b0;
    for (int u = 0; u < NU; u++) begin
      logic rxf = rx_use_full_i[u] ? rx_full_i[u] : rx_rdy_i[u];
      logic [3:0] st = {brk_chg_i[u], cts_chg_i[u], rxf, tx_rdy_i[u]};
      i |= |(st & irq_mask_i[4*u +: 4]);
    end
    return i;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_req <= '0; m_hold <= '0; m_irq <= 1'b0;
    end else begin
      m_req  <= exp_raw() & ~(dma_ack_i & m_req) & ~m_hold;
      m_hold <= dma_ack_i & m_req;
      m_irq  <= exp_irq();
    end
  end

  task automatic chk_req(input logic [NC-1:0] exp, input string tag);
    checks++;
    if (dma_req_o !== exp) begin
      errors++;
      $display("FAIL %s req actual %b expected %b", tag, dma_req_o, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq_o, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(negedge clk_i);
    chk_req(m_req, tag);
    chk_irq(m_irq, tag);
  endtask

  task automatic clear_in();
    rx_rdy_i = '0; rx_full_i = '0; rx_use_full_i = '0; tx_rdy_i = '0;
    cts_chg_i = '0; brk_chg_i = '0; irq_mask_i = '0; req_map_i = '0; dma_ack_i = '0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5234));
    #9;
    chk_req('0, "R1");
    chk_irq(1'b0, "R1");
    @(negedge clk_i); rst_ni = 1'b1;
    cyc("R1");

    // R2: FIFO-full vs receive-ready select, rx0 -> ch2
    req_map_i = 20'h000A0; rx_full_i[0] = 1'b1;
    cyc("R2"); chk_req(8'h00, "R2");
    rx_use_full_i[0] = 1'b1;
    #1 chk_req(8'h00, "R6");
    cyc("R2"); chk_req(8'h04, "R2");
    clear_in(); cyc("R6"); chk_req(8'h00, "R6");

    // R3: tx0 -> ch5
    req_map_i = 20'h00D00; tx_rdy_i[0] = 1'b1;
    cyc("R3"); chk_req(8'h20, "R3");

    // R7: ack against a steady flag
    dma_ack_i[5] = 1'b1;
    cyc("R7"); chk_req(8'h00, "R7");
    dma_ack_i = '0;
    cyc("R7"); chk_req(8'h00, "R7");
    cyc("R7"); chk_req(8'h20, "R7");
    clear_in(); cyc("R6");

    // R4: disabled field, rx1 field -> ch3, channel out of range impossible at NC=8
    req_map_i = 20'h00500; tx_rdy_i[0] = 1'b1;
    cyc("R4"); chk_req(8'h00, "R4");
    tx_rdy_i = '0; req_map_i = 20'h0B000; rx_rdy_i[1] = 1'b1;
    cyc("R4"); chk_req(8'h08, "R4");
    clear_in(); cyc("R6");

    // R5: tx0 and tx1 share ch6
    req_map_i = 20'hE0E00; tx_rdy_i = 2'b01;
    cyc("R5"); chk_req(8'h40, "R5");
    tx_rdy_i = 2'b10;
    cyc("R5"); chk_req(8'h40, "R5");
    clear_in(); cyc("R6");

    // R8: ack on an idle channel together with a rising flag
    req_map_i = 20'h00900; tx_rdy_i[0] = 1'b1; dma_ack_i[1] = 1'b1;
    cyc("R8"); chk_req(8'h02, "R8");
    clear_in(); cyc("R6");

    // R9: receive interrupt enabled then masked
    rx_rdy_i[0] = 1'b1; irq_mask_i = 8'h02;
    cyc("R9"); chk_irq(1'b1, "R9");
    irq_mask_i = 8'h00;
    cyc("R9"); chk_irq(1'b0, "R9");

    // R10: CTS change on UART1 while its data is on DMA
    req_map_i = 20'hCB000; rx_rdy_i = 2'b10; tx_rdy_i = 2'b10;
    cts_chg_i[1] = 1'b1; irq_mask_i = 8'h40;
    cyc("R10"); chk_irq(1'b1, "R10"); chk_req(8'h18, "R10");
    cts_chg_i = '0; brk_chg_i[1] = 1'b1; irq_mask_i = 8'h80;
    cyc("R10"); chk_irq(1'b1, "R10");
    clear_in(); cyc("R6");

    // random phase
    for (int n = 0; n < 2000; n++) begin
      if (n % 50 == 0) begin
        req_map_i  = MW'($urandom) | 20'h88880;
        irq_mask_i = 8'($urandom);
      end
      rx_rdy_i      = NU'($urandom);
      rx_full_i     = NU'($urandom);
      rx_use_full_i = NU'($urandom);
      tx_rdy_i      = NU'($urandom) | NU'($urandom);
      cts_chg_i     = NU'($urandom) & NU'($urandom);
      brk_chg_i     = NU'($urandom) & NU'($urandom);
      dma_ack_i     = NC'($urandom);
      cyc((n % 2) ? "R7" : "R5");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule